// File: doc/BRIEF.md
# Grouped Interrupt Summary Controller

This block gathers a wide vector of per-pin interrupt requests into a compact summary and raises one interrupt line towards the processor. Every summary bit stands for a group of four neighbouring pins and is set while any pin of its group requests service. Software reads the summary through a small register window, services the flagged groups, and then writes an end-of-interrupt command.

The interrupt output is a single-cycle pulse. After it fires, the block disarms and stays silent, whatever the requests do, until software writes the end-of-interrupt bit. If any group is still pending at that moment, the line pulses again in the very next cycle, so no pending request is lost across the hand-back.

The register window uses simple read and write strobes with a byte address. The summary words sit at offsets 0x00 (bits 0 to 31) and 0x04 (bits 32 to 63). The control register sits at 0x08 and uses bit 0 as the end-of-interrupt command.

Top module: `grp_irq_summary`

## Requirements
- R1: After synchronous reset, irq_o is 0, rdata_o is 0, the summary is all zero and the block is armed.
- R2: Summary bit n equals the OR of pin requests 4n, 4n+1, 4n+2 and 4n+3, registered one clock after the pins are sampled; with 184 pins there are 46 such bits.
- R3: A read of byte offset 0x00 returns summary bits 0 to 31 in data bits 0 to 31; a read of offset 0x04 returns summary bits 32 to 45 in data bits 0 to 13.
- R4: Summary bits 46 to 63, which are data bits 14 to 31 of the word at offset 0x04, always read as 0.
- R5: When the block is armed and any summary bit is set, irq_o is high for exactly one clock, and the block disarms. While disarmed, irq_o stays 0 no matter how the requests change.
- R6: A write to offset 0x08 with data bit 0 set re-arms the block. If any summary bit is set at that clock edge, irq_o is high in the cycle right after the write.
- R7: The control register at 0x08 always reads as 0. A write to it with bit 0 clear has no effect and leaves the block disarmed.
- R8: Read data is registered and valid in the cycle after rd_en_i is sampled high. Reads of unmapped or unaligned offsets return 0.
- R9: Writes to the summary offsets 0x00 and 0x04 are ignored, and the summary keeps following the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_req_i | input | NUM_PINS (184) | Per-pin interrupt requests, level |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W (8) | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Summary interrupt pulse to the processor |

## Verification
The bench targets the group boundaries, meaning the first and last pin of a group and pin 183 in the last meaningful group. A design that mis-sliced the OR would flag the wrong bit or miss the high word. It holds a request steady after a pulse to catch a design that pulses repeatedly or leaves the line stuck high. It also writes the control register with bit 0 clear, which a design decoding the whole register as a command would wrongly treat as a re-arm. It writes the end-of-interrupt bit both with requests pending and with none pending, which exposes a design that loses the pending request or fires with no cause. Random sparse pin patterns check both summary words against a bench model, including the padding bits above bit 45.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
  localparam int WORD_W   = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int EOI_BIT  = 0;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/grp_irq_group_or.sv
module grp_irq_group_or #(
  parameter int NUM_PINS   = 184,
  parameter int GROUP_SIZE = 4,
  parameter int SUM_BITS   = 46
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] req_i,
  output logic [SUM_BITS-1:0] sum_o
);
  localparam int PAD_W = SUM_BITS * GROUP_SIZE;

  logic [PAD_W-1:0]    padded;
  logic [SUM_BITS-1:0] sum_d;

  always_comb begin
    padded = '0;
    padded[NUM_PINS-1:0] = req_i;
  end

  for (genvar g = 0; g < SUM_BITS; g++) begin : g_grp
    assign sum_d[g] = |padded[g*GROUP_SIZE +: GROUP_SIZE];
  end

  always_ff @(posedge clk) begin
    if (rst) sum_o <= '0;
    else     sum_o <= sum_d;
  end
endmodule

// File: rtl/grp_irq_arm_ctrl.sv
module grp_irq_arm_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic any_i,
  input  logic eoi_i,
  output logic irq_o
);
  logic armed;
  logic fire;

  assign fire = (armed | eoi_i) & any_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b1;
      irq_o <= 1'b0;
    end else begin
      irq_o <= fire;
      if (fire)       armed <= 1'b0;
      else if (eoi_i) armed <= 1'b1;
    end
  end

  AST_REARM_NEEDS_EOI: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(eoi_i)); // R6
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !eoi_i) |=> !irq_o); // R5
  AST_FIRE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(any_i)); // R5
endmodule

// File: rtl/grp_irq_reg_if.sv
module grp_irq_reg_if
  import grp_irq_pkg::*;
#(
  parameter int SUM_BITS  = 46,
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [WORD_W-1:0]   wdata_i,
  input  logic [SUM_BITS-1:0] sum_i,
  output logic [WORD_W-1:0]   rdata_o,
  output logic                eoi_o
);
  localparam int VEC_W   = NUM_WORDS * WORD_W;
  localparam int IDX_W   = ADDR_W - 2;
  localparam int HI_USED = SUM_BITS - (NUM_WORDS - 1) * WORD_W;

  logic [VEC_W-1:0]  sum_vec;
  logic [IDX_W-1:0]  idx;
  logic              aligned;
  logic              hit_ctrl;
  logic [WORD_W-1:0] rd_d;
  logic              wdata_unused;

  always_comb begin
    sum_vec = '0;
    sum_vec[SUM_BITS-1:0] = sum_i;
  end

  assign idx      = addr_i[ADDR_W-1:2];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign hit_ctrl = aligned && (idx == IDX_W'(NUM_WORDS));
  assign eoi_o    = wr_en_i && hit_ctrl && wdata_i[EOI_BIT];
  assign wdata_unused = ^wdata_i;

  always_comb begin
    rd_d = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (aligned && idx == IDX_W'(w)) rd_d = sum_vec[w*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_d;
  end

  AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en_i && hit_ctrl) |-> (rdata_o == '0)); // R7

  if (HI_USED < WORD_W) begin : g_pad_chk
    AST_PAD_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
      $past(rd_en_i && aligned && idx == IDX_W'(NUM_WORDS - 1))
      |-> (rdata_o[WORD_W-1:HI_USED] == '0)); // R4
  end
endmodule

// File: rtl/grp_irq_summary.sv
module grp_irq_summary
  import grp_irq_pkg::*;
#(
  parameter int NUM_PINS   = 184,
  parameter int GROUP_SIZE = 4,
  parameter int ADDR_W     = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_req_i,
  input  logic                rd_en_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic                irq_o
);
  localparam int SUM_BITS  = ceil_div(NUM_PINS, GROUP_SIZE);
  localparam int NUM_WORDS = ceil_div(SUM_BITS, WORD_W);

  logic [SUM_BITS-1:0] sum_q;
  logic                eoi;

  grp_irq_group_or #(
    .NUM_PINS  (NUM_PINS),
    .GROUP_SIZE(GROUP_SIZE),
    .SUM_BITS  (SUM_BITS)
  ) u_group (
    .clk  (clk),
    .rst  (rst),
    .req_i(pin_req_i),
    .sum_o(sum_q)
  );

  grp_irq_reg_if #(
    .SUM_BITS (SUM_BITS),
    .NUM_WORDS(NUM_WORDS),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .rd_en_i(rd_en_i),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .sum_i  (sum_q),
    .rdata_o(rdata_o),
    .eoi_o  (eoi)
  );

  grp_irq_arm_ctrl u_arm (
    .clk  (clk),
    .rst  (rst),
    .any_i(|sum_q),
    .eoi_i(eoi),
    .irq_o(irq_o)
  );

  AST_GROUP_FOLLOWS_PINS: assert property (@(posedge clk) disable iff (rst)
    $past(pin_req_i[GROUP_SIZE-1:0] != '0) |-> sum_q[0]); // R2
endmodule

// File: tb/grp_irq_summary_tb_top.sv
module grp_irq_summary_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 184;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NPINS-1:0] pins = '0;
  logic             rd_en = 1'b0;
  logic             wr_en = 1'b0;
  logic [7:0]       addr = '0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic             irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  grp_irq_summary dut_i (
    .clk(clk), .rst(rst), .pin_req_i(pins), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [63:0] model_sum(input logic [NPINS-1:0] p);
    logic [63:0] s = '0;
    for (int n = 0; n < 46; n++) s[n] = |p[4*n +: 4];
    return s;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    tick();
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0; wdata = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] e;
    logic [NPINS-1:0] v;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 irq after reset", {63'b0, irq}, 64'd0);
    check("R1 rdata after reset", {32'b0, rdata}, 64'd0);
    repeat (3) tick();
    check("R1 armed, no request no irq", {63'b0, irq}, 64'd0);

    // R2 R5: pin 5 lies in group 1
    pins[5] = 1'b1;
    tick();
    check("R5 no irq before summary settles", {63'b0, irq}, 64'd0);
    tick();
    check("R5 irq pulse", {63'b0, irq}, 64'd1);
    tick();
    check("R5 pulse lasts one cycle", {63'b0, irq}, 64'd0);
    pins[7] = 1'b1; pins[40] = 1'b1;
    begin
      int hits = 0;
      for (int k = 0; k < 8; k++) begin tick(); if (irq) hits++; end
      check("R5 disarmed stays silent", 64'(hits), 64'd0);
    end
    rd(8'h00, d);
    check("R2 R3 low word groups 1 and 10", {32'b0, d}, 64'h402);

    // R7: control write with bit0 clear does nothing
    wr(8'h08, 32'hFFFF_FFFE);
    tick(); tick();
    check("R7 write without EOI keeps disarmed", {63'b0, irq}, 64'd0);
    rd(8'h08, d);
    check("R7 control reads zero", {32'b0, d}, 64'd0);

    // R6: EOI with pending request fires next cycle
    wr(8'h08, 32'h1);
    check("R6 EOI with pending fires next cycle", {63'b0, irq}, 64'd1);
    tick();
    check("R6 re-fire is one pulse", {63'b0, irq}, 64'd0);

    // R6: EOI with nothing pending arms silently
    pins = '0;
    tick();
    wr(8'h08, 32'h1);
    check("R6 EOI with nothing pending", {63'b0, irq}, 64'd0);
    pins[183] = 1'b1;
    tick(); tick();
    check("R5 armed irq from last group", {63'b0, irq}, 64'd1);
    rd(8'h04, d);
    check("R3 high word bit 45", {32'b0, d}, 64'h2000);
    pins[0] = 1'b1;
    tick();
    rd(8'h00, d);
    check("R2 group 0 first pin", {32'b0, d}, 64'h1);

    // R9 and R8
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h00, d);
    check("R9 write to low word ignored", {32'b0, d}, 64'h1);
    rd(8'h04, d);
    check("R9 write to high word ignored", {32'b0, d}, 64'h2000);
    rd(8'h0C, d);
    check("R8 unmapped offset reads zero", {32'b0, d}, 64'd0);
    rd(8'h01, d);
    check("R8 unaligned offset reads zero", {32'b0, d}, 64'd0);

    // Random sparse patterns, summary words against model (R2 R3 R4)
    for (int it = 0; it < 60; it++) begin
      for (int b = 0; b < NPINS; b++) v[b] = ($urandom % 9 == 0);
      if (it == 0) v = '1;
      pins = v;
      tick();
      e = model_sum(v);
      rd(8'h00, d);
      check("R2 R3 random low word", {32'b0, d}, {32'b0, e[31:0]});
      rd(8'h04, d);
      check("R3 R4 random high word", {32'b0, d}, {32'b0, e[63:32]});
    end

    // R1: reset again in mid-run
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R1 irq cleared by reset", {63'b0, irq}, 64'd0);
    check("R1 rdata cleared by reset", {32'b0, rdata}, 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule